// File: doc/BRIEF.md
# Dual-Direction Bus Transceiver with Selectable Pass, Hold and Capture

This block connects two equal-width data buses, A and B, and moves data between them without inversion. Each direction has a storage stage fed from its source bus. A level control picks the stage's behaviour. While that control is high the stage is transparent, so the far bus follows the source. While it is low the stage holds its value, and a rising edge on that direction's clock loads a fresh sample from the source bus.

Each direction drives its far bus through a three-state driver with its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. An asynchronous reset clears both stages to zero and turns both drivers off for as long as it is asserted. A status output goes high whenever both drivers are on together, because the two directions would then fight over the buses.

Top module: `xcvr_top`

## Requirements
- R1: With `ab_pass` high and `ab_drive` high, `b_bus` equals `a_bus` bit for bit, with no inversion.
- R2: With `ab_pass` low and `ab_clk` at a steady level, `b_bus` keeps the stored value whatever `a_bus` does.
- R3: With `ab_pass` low, a rising edge of `ab_clk` stores the current `a_bus` value, and `b_bus` shows it from then on. A falling edge of `ab_clk` changes nothing.
- R4: `ab_drive` is active high. When it is 0 the block does not drive `b_bus`, so a value driven onto `b_bus` from outside reads back unchanged.
- R5: The B-to-A path has the same pass, hold and capture behaviour, using `ba_pass`, `ba_clk` and `b_bus` as its source. Its enable `ba_drive_n` is active low: 0 drives `a_bus` and 1 releases it.
- R6: While `rst` is 1, both stored values are zero, neither bus is driven and `contention` is 0. After release, with the pass controls low, the driven bus reads zero until the first capture.
- R7: A clock edge while the pass control is high has no effect beyond the pass-through. When the pass control falls, the value present at the fall is the one held.
- R8: `contention` is 1 exactly when both drivers are enabled (`ab_drive`=1, `ba_drive_n`=0, `rst`=0). While both are enabled, each bus carries its own direction's held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_bus | inout | W (18) | Bus A: source of the A-to-B path, driven by the B-to-A path |
| b_bus | inout | W (18) | Bus B: source of the B-to-A path, driven by the A-to-B path |
| ab_drive | input | 1 | A-to-B driver enable, active high |
| ab_pass | input | 1 | A-to-B stage transparent when high |
| ab_clk | input | 1 | A-to-B capture clock, rising edge |
| ba_drive_n | input | 1 | B-to-A driver enable, active low |
| ba_pass | input | 1 | B-to-A stage transparent when high |
| ba_clk | input | 1 | B-to-A capture clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| contention | output | 1 | High when both drivers are enabled at once |

## Verification
The bench drives each bus only while the block leaves it free. It goes after three kinds of error. A stage that reloads on a clock edge during pass-through would hold a stale word once the pass control falls. A stage that reacts to the falling clock edge would change value when it should not. A swapped enable polarity would fight the bench on the bus, or show a driven word where an external value should read back. Random mixes of pass, clock and enable levels on both paths are compared against a bench model. Directed cases cover the reset state, the pass-control fall, and the both-enabled case, where a wrong `contention` output or a wrong held word shows up directly.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W_DEFAULT = 18;

  // Driver-enable decode: pin level vs. polarity, gated off by reset.
  function automatic logic drive_on(input logic pin, input logic act_high, input logic rst);
    return !rst && (act_high ? pin : !pin);
  endfunction
endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage #(
  parameter int unsigned W = xcvr_pkg::XCVR_W_DEFAULT
) (
  input  logic         rst,
  input  logic         pass,
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] held,
  output logic [W-1:0] dout
);
  logic [W-1:0] lat_q;
  logic [W-1:0] ff_q;
  logic         ff_newer;

  // Level-sensitive part: follows din while pass is high.
  always_latch begin
    if (rst)       lat_q = '0;
    else if (pass) lat_q = din;
  end

  // Edge part: samples din on a rising clock while not passing.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)        ff_q <= '0;
    else if (!pass) ff_q <= din;
  end

  // Tracks which half holds the newest word; pass-through forces the latch.
  always_ff @(posedge clk or posedge rst or posedge pass) begin
    if (rst)       ff_newer <= 1'b0;
    else if (pass) ff_newer <= 1'b0;
    else           ff_newer <= 1'b1;
  end

  assign held = ff_newer ? ff_q : lat_q;
  assign dout = pass ? din : held;
endmodule

// File: rtl/xcvr_oe.sv
module xcvr_oe #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic rst,
  input  logic pin,
  output logic en
);
  assign en = xcvr_pkg::drive_on(pin, ACT_HIGH, rst);
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
  parameter int unsigned W = xcvr_pkg::XCVR_W_DEFAULT
) (
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus,
  input  logic         ab_drive,
  input  logic         ab_pass,
  input  logic         ab_clk,
  input  logic         ba_drive_n,
  input  logic         ba_pass,
  input  logic         ba_clk,
  input  logic         rst,
  output logic         contention
);
  localparam logic [W-1:0] HIZ = {W{1'bz}};

  logic [W-1:0] ab_held, ab_out, ba_held, ba_out;
  logic         ab_en, ba_en;

  xcvr_stage #(.W(W)) u_ab (
    .rst(rst), .pass(ab_pass), .clk(ab_clk), .din(a_bus), .held(ab_held), .dout(ab_out)
  );
  xcvr_stage #(.W(W)) u_ba (
    .rst(rst), .pass(ba_pass), .clk(ba_clk), .din(b_bus), .held(ba_held), .dout(ba_out)
  );

  xcvr_oe #(.ACT_HIGH(1'b1)) u_ab_oe (.rst(rst), .pin(ab_drive),   .en(ab_en));
  xcvr_oe #(.ACT_HIGH(1'b0)) u_ba_oe (.rst(rst), .pin(ba_drive_n), .en(ba_en));

  assign b_bus = ab_en ? ab_out : HIZ;
  assign a_bus = ba_en ? ba_out : HIZ;

  assign contention = ab_en & ba_en;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         rst,
  input logic         ab_drive,
  input logic         ab_pass,
  input logic         ab_clk,
  input logic         ba_drive_n,
  input logic         ab_en,
  input logic         ba_en,
  input logic [W-1:0] ab_held,
  input logic [W-1:0] ba_held,
  input logic [W-1:0] ab_out,
  input logic [W-1:0] a_bus,
  input logic         contention
);
  always_comb begin
    if (rst === 1'b1) begin
      assert_reset_state_R6: assert (!ab_en && !ba_en && ab_held == '0 && ba_held == '0 && !contention);
    end
    if (rst === 1'b0) begin
      assert_ab_polarity_R4: assert (ab_en == ab_drive);
      assert_ba_polarity_R5: assert (ba_en == !ba_drive_n);
      assert_contention_flag_R8: assert (contention == (ab_drive && !ba_drive_n));
    end
  end

  property p_pass_follows;
    @(posedge ab_clk) disable iff (rst) ab_pass |-> (ab_out == a_bus);
  endproperty
  assert_pass_follows_R1: assert property (p_pass_follows);
endmodule

bind xcvr_top xcvr_chk #(.W(W)) u_chk (
  .rst(rst), .ab_drive(ab_drive), .ab_pass(ab_pass), .ab_clk(ab_clk),
  .ba_drive_n(ba_drive_n), .ab_en(ab_en), .ba_en(ba_en),
  .ab_held(ab_held), .ba_held(ba_held), .ab_out(ab_out), .a_bus(a_bus),
  .contention(contention)
);

// File: tb/tb_xcvr_top.sv
`timescale 1ns/1ps
module tb_xcvr_top;
  localparam int W = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  tri   [W-1:0] a_bus, b_bus;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  logic         tb_a_en = 1'b0, tb_b_en = 1'b0;
  logic ab_drive = 0, ab_pass = 0, ab_clk = 0, ba_drive_n = 1, ba_pass = 0, ba_clk = 0, rst = 1;
  logic contention;

  assign a_bus = tb_a_en ? tb_a : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b : {W{1'bz}};

  xcvr_top #(.W(W)) dut (
    .a_bus(a_bus), .b_bus(b_bus), .ab_drive(ab_drive), .ab_pass(ab_pass), .ab_clk(ab_clk),
    .ba_drive_n(ba_drive_n), .ba_pass(ba_pass), .ba_clk(ba_clk), .rst(rst), .contention(contention)
  );

  int checks = 0, failures = 0, cycles = 0;
  logic [W-1:0] h_ab = '0, h_ba = '0, exp_a = '0, exp_b = '0;
  logic ab_edge = 0, ba_edge = 0;

  function automatic logic [W-1:0] stage_view(input logic pass, input logic [W-1:0] src, input logic [W-1:0] held);
    return pass ? src : held;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Bench model of the settled bus values; pass-through stages track their source.
  task automatic settle();
    logic ab_on, ba_on;
    ab_on = ab_drive && !rst;
    ba_on = !ba_drive_n && !rst;
    if (ab_on && ba_on) begin
      exp_a = h_ba; exp_b = h_ab;
    end else if (ab_on) begin
      exp_a = tb_a;
      exp_b = stage_view(ab_pass, exp_a, h_ab);
      if (ab_pass) h_ab = exp_a;
      if (ba_pass) h_ba = exp_b;
    end else if (ba_on) begin
      exp_b = tb_b;
      exp_a = stage_view(ba_pass, exp_b, h_ba);
      if (ba_pass) h_ba = exp_b;
      if (ab_pass) h_ab = exp_a;
    end else begin
      exp_a = tb_a; exp_b = tb_b;
      if (ab_pass) h_ab = exp_a;
      if (ba_pass) h_ba = exp_b;
    end
  endtask

  task automatic apply(input logic npa, input logic npb, input logic nda, input logic ndbn,
                       input logic nca, input logic ncb, input logic [W-1:0] na, input logic [W-1:0] nb);
    @(posedge clk);
    ab_pass = npa; ba_pass = npb; ab_drive = nda; ba_drive_n = ndbn;
    tb_a_en = ndbn; tb_b_en = !nda;
    #1 settle();
    tb_a = na; tb_b = nb;
    #1 settle();
    ab_edge = nca && !ab_clk; ba_edge = ncb && !ba_clk;
    ab_clk = nca; ba_clk = ncb;
    #1;
    if (ab_edge && !ab_pass) h_ab = exp_a;
    if (ba_edge && !ba_pass) h_ba = exp_b;
    settle();
    #1;
  endtask

  task automatic check_buses();
    string ta, tbs;
    checks++;
    if ((tb_a_en && !ba_drive_n) || (tb_b_en && ab_drive)) begin
      failures++;
      $display("FAIL R8 two drivers on a bus actual=1 expected=0");
    end
    if (!ab_drive) tbs = "R4";
    else if (ab_pass) tbs = "R1";
    else if (ab_edge) tbs = "R3";
    else tbs = "R2";
    ta = "R5";
    check(tbs, b_bus, exp_b);
    check(ta, a_bus, exp_a);
    check("R8", {{(W-1){1'b0}}, contention}, '0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] x1, x2;
    void'($urandom(32'h5eed_1234));
    // R6: reset with both enable pins active; the bench drives both buses and reads them back.
    ab_drive = 1; ba_drive_n = 0; tb_a_en = 1; tb_b_en = 1;
    tb_a = 18'h2A5A5; tb_b = 18'h15A5A;
    #3;
    check("R6", a_bus, 18'h2A5A5);
    check("R6", b_bus, 18'h15A5A);
    check("R6", {{(W-1){1'b0}}, contention}, '0);
    ba_drive_n = 1; tb_b_en = 0;
    @(posedge clk); #1 rst = 0; #2;
    check("R6", b_bus, '0);
    exp_a = tb_a;

    // R7: a clock edge during pass-through, then the pass control falls.
    x1 = 18'h12345; x2 = 18'h0BEEF;
    apply(1, 0, 1, 1, 0, 0, x1, 0);
    apply(1, 0, 1, 1, 1, 0, x1, 0);
    check("R7", b_bus, x1);
    apply(1, 0, 1, 1, 0, 0, x2, 0);
    check("R7", b_bus, x2);
    apply(0, 0, 1, 1, 0, 0, x2, 0);
    check("R7", b_bus, x2);
    apply(0, 0, 1, 1, 0, 0, x1, 0);
    check("R7", b_bus, x2);

    // R3: a falling edge leaves the held word alone; a rising edge captures.
    apply(0, 0, 1, 1, 1, 0, x1, 0);
    check("R3", b_bus, x1);
    apply(0, 0, 1, 1, 0, 0, 18'h3FFFF, 0);
    check("R3", b_bus, x1);
    apply(0, 0, 1, 1, 1, 0, 18'h3FFFF, 0);
    check("R3", b_bus, 18'h3FFFF);

    // R5: B-to-A capture with active-low enable.
    apply(0, 0, 0, 0, 0, 0, 0, 18'h0F0F0);
    apply(0, 0, 0, 0, 0, 1, 0, 18'h0F0F0);
    check("R5", a_bus, 18'h0F0F0);

    // R8: both drivers on, both paths holding.
    apply(0, 0, 1, 0, 0, 0, 0, 0);
    checks++;
    if (contention !== 1'b1) begin
      failures++;
      $display("FAIL R8 contention actual=%b expected=1", contention);
    end
    check("R8", a_bus, 18'h0F0F0);
    check("R8", b_bus, 18'h3FFFF);
    apply(0, 0, 1, 1, 0, 0, 0, 0);
    check("R8", {{(W-1){1'b0}}, contention}, '0);

    // Random mix of pass, clock and enable levels, never both enabled.
    for (int i = 0; i < 3000; i++) begin
      logic da, dbn;
      da = 1'($urandom); dbn = 1'($urandom);
      if (da && !dbn) dbn = 1;
      apply(1'($urandom), 1'($urandom), da, dbn, 1'($urandom), 1'($urandom),
            W'($urandom), W'($urandom));
      check_buses();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule